// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver with Address Filtering

This block recovers asynchronous serial words from a single receive line. An external oversample strobe pulses sixteen times per bit period. Each bit's level is decided by a two-out-of-three vote over the samples taken on oversample ticks 7, 8 and 9 of that bit. A frame is one low start bit, then 8 or 9 data bits with the least significant bit first, then one high stop bit. A finished word goes into a two-entry queue. Each entry stores the data byte, the ninth bit and a framing-error bit. The queue head is always visible on the outputs. A read strobe removes the head.

A four-state controller runs the frame. ST_IDLE waits for a tick that sees the line low, then moves to ST_START. ST_START goes back to ST_IDLE if the mid-bit vote reads high. Otherwise it moves to ST_DATA at the end of the bit. ST_DATA moves to ST_STOP after the last data bit. ST_STOP decides the word at its mid-bit vote and returns to ST_IDLE.

Clearing the receive enable forces ST_IDLE from any state. If a word arrives while the queue is full, a sticky overrun flag is set. The overrun flag blocks all loads until the enable is cleared. In 9-bit mode with address filtering on, words whose ninth bit is 0 are discarded.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset, data_avail, overrun, head_data, head_bit8 and head_ferr are all 0.
- R2: A bit's level is the majority of the line samples on oversample ticks 7, 8 and 9 of that bit, so one disagreeing sample among the three does not change the received value.
- R3: A start bit whose mid-bit vote reads high is dropped. The receiver returns to idle, no word is produced, and a later valid frame is received normally.
- R4: In 8-bit mode (nine_bit=0), the first data bit after the start bit lands in head_data[0] and the eighth lands in head_data[7]. head_bit8 reads 0.
- R5: In 9-bit mode (nine_bit=1), the ninth data bit on the line is stored and shown on head_bit8.
- R6: A word whose stop bit votes low is stored with head_ferr=1, and a word with a high stop bit is stored with head_ferr=0. The flag belongs to its own entry and changes only when the head advances.
- R7: The queue holds two words in arrival order. data_avail is 1 whenever at least one word is held. A read that empties the queue clears data_avail.
- R8: If a word completes (and is not filtered) while both entries are full and no read happens in that cycle, overrun is set. The word is lost and the held entries are unchanged.
- R9: While overrun is 1, no word is loaded, even after a read frees space. Driving rx_en low clears overrun and returns the receiver to idle. Held entries stay readable.
- R10: With nine_bit=1 and addr_det=1, a word whose ninth bit is 0 is neither loaded nor able to set overrun, and a word whose ninth bit is 1 is loaded. With nine_bit=0, addr_det has no effect.
- R11: A read strobe while data_avail is 0 has no effect: the next word received becomes the head, and a single read then empties the queue.
- R12: If a read and the completion of a word fall in the same cycle on a full queue, the head is removed and the new word is accepted without setting overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Serial receive line, idle high, already synchronous to clk |
| os_tick | input | 1 | One-cycle strobe, sixteen per bit period |
| rx_en | input | 1 | Receive enable; low holds the receiver idle and clears overrun |
| nine_bit | input | 1 | 1 selects nine data bits per frame |
| addr_det | input | 1 | 1 discards 9-bit words whose ninth bit is 0 |
| rd_pop | input | 1 | Removes the queue head |
| head_data | output | 8 | Data byte of the queue head |
| head_bit8 | output | 1 | Ninth bit of the queue head |
| head_ferr | output | 1 | Framing-error bit of the queue head |
| data_avail | output | 1 | Queue holds at least one word |
| overrun | output | 1 | Sticky overrun flag |

## Verification
A read strobe and the completion of a word can fall in the same clock cycle. The bench provokes this by filling the queue and then raising the read strobe in the cycle right after the stop bit's ninth tick, which is the cycle in which the word is written. It judges the result by checking that overrun stays 0, that the oldest word has left, and that the new word is now the second entry. The same collision without a read, on a full queue, is checked to set overrun. Random frames with single-sample glitches, random reads and random mode settings are compared against a queue model kept in the bench.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    localparam int RX_DATA_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic                 ferr;
        logic                 bit8;
        logic [RX_DATA_W-1:0] data;
    } rx_word_t;
endpackage

// File: rtl/rx_vote.sv
module rx_vote #(
    parameter int OS_RATE = 16,
    parameter int CW      = $clog2(OS_RATE + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic [CW-1:0] tick_n,
    input  logic          rx_line,
    output logic          vote
);
    localparam int MID = OS_RATE / 2;

    logic samp_a;
    logic samp_b;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_a <= 1'b1;
            samp_b <= 1'b1;
        end else if (os_tick) begin
            if (tick_n == CW'(MID - 1)) samp_a <= rx_line;
            if (tick_n == CW'(MID))     samp_b <= rx_line;
        end
    end

    // third sample is the live line on the tick after samp_b
    assign vote = (samp_a & samp_b) | (samp_a & rx_line) | (samp_b & rx_line);
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int OS_RATE = 16,
    parameter int DATA_W  = RX_DATA_W
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rx_en,
    input  logic     nine_bit,
    input  logic     os_tick,
    input  logic     rx_line,
    output logic     word_valid,
    output rx_word_t word
);
    localparam int CW  = $clog2(OS_RATE + 1);
    localparam int IW  = $clog2(DATA_W + 1);
    localparam int MID = OS_RATE / 2;

    rx_state_e       state;
    rx_state_e       state_nx;
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   tick_n;
    logic [IW-1:0]   idx;
    logic [IW-1:0]   last_idx;
    logic [DATA_W:0] shreg;
    logic            vote;
    logic            at_mid;
    logic            at_end;
    logic            start_seen;

    assign tick_n     = cnt + 1'b1;
    assign at_mid     = os_tick && (tick_n == CW'(MID + 1));
    assign at_end     = os_tick && (tick_n == CW'(OS_RATE));
    assign start_seen = os_tick && !rx_line;
    assign last_idx   = nine_bit ? IW'(DATA_W) : IW'(DATA_W - 1);

    rx_vote #(.OS_RATE(OS_RATE), .CW(CW)) i_vote (
        .clk     (clk),
        .rst_n   (rst_n),
        .os_tick (os_tick),
        .tick_n  (tick_n),
        .rx_line (rx_line),
        .vote    (vote)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) state <= ST_IDLE;
        else                  state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start_seen) state_nx = ST_START;
            ST_START: begin
                if (at_mid && vote) state_nx = ST_IDLE;
                else if (at_end)    state_nx = ST_DATA;
            end
            ST_DATA:  if (at_end && idx == last_idx) state_nx = ST_STOP;
            ST_STOP:  if (at_mid) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // tick counter, bit index and shift register
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) begin
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
        end else if (state == ST_IDLE) begin
            cnt <= start_seen ? CW'(1) : '0;
            idx <= '0;
        end else if (os_tick) begin
            cnt <= at_end ? '0 : tick_n;
            if (state == ST_DATA && at_mid) shreg[idx] <= vote;
            if (state == ST_DATA && at_end) idx <= idx + 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            word       <= '0;
        end else begin
            word_valid <= rx_en && (state == ST_STOP) && at_mid;
            if (rx_en && (state == ST_STOP) && at_mid) begin
                word.ferr <= ~vote;
                word.bit8 <= nine_bit & shreg[DATA_W];
                word.data <= shreg[DATA_W-1:0];
            end
        end
    end
endmodule

// File: rtl/rx_word_fifo.sv
module rx_word_fifo #(
    parameter int DEPTH = 2,
    parameter int W     = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         not_empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [NW-1:0] count;
    logic          pop_ok;

    assign not_empty = (count != '0);
    assign full      = (count == NW'(DEPTH));
    assign pop_ok    = pop && not_empty;
    assign rdata     = not_empty ? mem[rd_ptr] : '0;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)   wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok) rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (push && !pop_ok)      count <= count + 1'b1;
            else if (!push && pop_ok) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
    import uart_rx_pkg::*;
#(
    parameter int OS_RATE = 16,
    parameter int DEPTH   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_line,
    input  logic                 os_tick,
    input  logic                 rx_en,
    input  logic                 nine_bit,
    input  logic                 addr_det,
    input  logic                 rd_pop,
    output logic [RX_DATA_W-1:0] head_data,
    output logic                 head_bit8,
    output logic                 head_ferr,
    output logic                 data_avail,
    output logic                 overrun
);
    localparam int WW = $bits(rx_word_t);

    rx_word_t word;
    rx_word_t head;
    logic     word_valid;
    logic     word_bit8;
    logic     keep;
    logic     room;
    logic     full;
    logic     push_en;

    rx_frame_fsm #(.OS_RATE(OS_RATE), .DATA_W(RX_DATA_W)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .nine_bit   (nine_bit),
        .os_tick    (os_tick),
        .rx_line    (rx_line),
        .word_valid (word_valid),
        .word       (word)
    );

    assign word_bit8 = word.bit8;
    assign keep      = !(nine_bit && addr_det && !word_bit8);
    assign room      = !full || (rd_pop && data_avail);
    assign push_en   = rx_en && word_valid && keep && !overrun && room;

    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) overrun <= 1'b0;
        else if (word_valid && keep && !overrun && !room) overrun <= 1'b1;
    end

    rx_word_fifo #(.DEPTH(DEPTH), .W(WW)) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_en),
        .pop       (rd_pop),
        .wdata     (word),
        .rdata     (head),
        .not_empty (data_avail),
        .full      (full)
    );

    assign head_data = head.data;
    assign head_bit8 = head.bit8;
    assign head_ferr = head.ferr;
endmodule

// File: rtl/uart_addr_rx_chk.sv
module uart_addr_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_en,
    input logic nine_bit,
    input logic addr_det,
    input logic rd_pop,
    input logic data_avail,
    input logic overrun,
    input logic word_valid,
    input logic word_bit8
);
    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && rx_en |=> overrun);

    assert_overrun_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !overrun);

    assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(word_valid) && $past(data_avail));

    assert_empty_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !data_avail && rd_pop && !word_valid |=> !data_avail);

    assert_addr_filter_R10: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && nine_bit && addr_det && !word_bit8 && !rd_pop
        |=> $stable(data_avail) && $stable(overrun));
endmodule

bind uart_addr_rx uart_addr_rx_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .nine_bit   (nine_bit),
    .addr_det   (addr_det),
    .rd_pop     (rd_pop),
    .data_avail (data_avail),
    .overrun    (overrun),
    .word_valid (word_valid),
    .word_bit8  (word_bit8)
);

// File: tb/test_uart_addr_rx.sv
`timescale 1ns/1ps
module test_uart_addr_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       os_tick = 1'b0;
    logic       rx_en = 1'b0;
    logic       nine_bit = 1'b0;
    logic       addr_det = 1'b0;
    logic       rd_pop = 1'b0;
    logic [7:0] head_data;
    logic       head_bit8;
    logic       head_ferr;
    logic       data_avail;
    logic       overrun;

    int n_chk = 0;
    int n_fail = 0;

    // model: {ferr, bit8, data}
    logic [9:0] m_q [2];
    int         m_cnt = 0;
    logic       m_ovr = 1'b0;

    always #2.5 clk = ~clk;

    uart_addr_rx i_uart_addr_rx (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
        .rx_en(rx_en), .nine_bit(nine_bit), .addr_det(addr_det), .rd_pop(rd_pop),
        .head_data(head_data), .head_bit8(head_bit8), .head_ferr(head_ferr),
        .data_avail(data_avail), .overrun(overrun)
    );

    function automatic logic exp_keep(input logic nb, input logic ad, input logic b8);
        return !(nb && ad && !b8);
    endfunction

    function automatic logic [9:0] exp_word(input logic [8:0] d, input logic nb, input logic stop);
        return {~stop, nb & d[8], d[7:0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic [9:0] hd;
        hd = {head_ferr, head_bit8, head_data};
        chk(data_avail == (m_cnt > 0), {tag, " data_avail"}, 16'(data_avail), 16'(m_cnt > 0));
        chk(overrun == m_ovr, {tag, " overrun"}, 16'(overrun), 16'(m_ovr));
        if (m_cnt > 0) chk(hd == m_q[0], {tag, " head"}, 16'(hd), 16'(m_q[0]));
    endtask

    task automatic model_pop();
        if (m_cnt > 0) begin
            m_q[0] = m_q[1];
            m_cnt--;
        end
    endtask

    task automatic tick_cycle(input logic lvl, input logic pop);
        @(negedge clk);
        rx_line = lvl;
        os_tick = 1'b1;
        @(negedge clk);
        os_tick = 1'b0;
        rd_pop  = pop;
        @(negedge clk);
        rd_pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_bit(input logic lvl, input int g, input logic pop9);
        for (int i = 1; i <= 16; i++)
            tick_cycle((i == g) ? ~lvl : lvl, pop9 && (i == 9));
    endtask

    // g_bit: 0 start, 1..n data, n+1 stop; g_idx: tick to flip (0 none)
    task automatic send_frame(input logic [8:0] d, input logic stop, input int g_bit,
                              input int g_idx, input logic pop_stop);
        int nb;
        logic [9:0] w;
        nb = nine_bit ? 9 : 8;
        send_bit(1'b0, (g_bit == 0) ? g_idx : 0, 1'b0);
        for (int b = 0; b < nb; b++) send_bit(d[b], (g_bit == b + 1) ? g_idx : 0, 1'b0);
        send_bit(stop, (g_bit == nb + 1) ? g_idx : 0, pop_stop);
        tick_cycle(1'b1, 1'b0);
        tick_cycle(1'b1, 1'b0);
        if (pop_stop) model_pop();
        w = exp_word(d, nine_bit, stop);
        if (rx_en && !m_ovr && exp_keep(nine_bit, addr_det, w[8])) begin
            if (m_cnt == 2) m_ovr = 1'b1;
            else begin
                m_q[m_cnt] = w;
                m_cnt++;
            end
        end
    endtask

    task automatic do_read(input string tag);
        @(negedge clk);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        model_pop();
        check_all(tag);
    endtask

    task automatic toggle_en();
        @(negedge clk);
        rx_en = 1'b0;
        repeat (3) @(negedge clk);
        rx_en = 1'b1;
        m_ovr = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd7391));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({head_data, head_bit8, head_ferr, data_avail, overrun} == '0, "R1 reset outputs",
            16'({head_data, head_bit8, head_ferr, data_avail, overrun}), 16'h0);
        rx_en = 1'b1;
        repeat (2) @(negedge clk);

        // R4 8-bit frame, LSB first
        send_frame(9'h0A5, 1'b1, -1, 0, 1'b0);
        check_all("R4 8-bit word");
        do_read("R7 read empties");

        // R2 single disagreeing samples inside the vote window
        send_frame(9'h03C, 1'b1, 3, 8, 1'b0);
        check_all("R2 glitch tick8");
        do_read("R2 read");
        send_frame(9'h0C3, 1'b1, 6, 7, 1'b0);
        check_all("R2 glitch tick7");
        do_read("R2 read");
        send_frame(9'h05A, 1'b1, 0, 9, 1'b0);
        check_all("R2 glitch start tick9");
        do_read("R2 read");

        // R3 false start
        for (int i = 0; i < 3; i++) tick_cycle(1'b0, 1'b0);
        for (int i = 0; i < 24; i++) tick_cycle(1'b1, 1'b0);
        check_all("R3 false start no word");
        send_frame(9'h081, 1'b1, -1, 0, 1'b0);
        check_all("R3 frame after false start");
        do_read("R3 read");

        // R6 framing error per entry
        send_frame(9'h011, 1'b0, -1, 0, 1'b0);
        send_frame(9'h022, 1'b1, -1, 0, 1'b0);
        check_all("R6 ferr head");
        do_read("R6 ferr advances");
        do_read("R7 second read");

        // R5 9-bit mode
        nine_bit = 1'b1;
        send_frame(9'h1A5, 1'b1, -1, 0, 1'b0);
        check_all("R5 ninth bit set");
        send_frame(9'h04B, 1'b1, -1, 0, 1'b0);
        do_read("R5 ninth bit clear");
        do_read("R5 read");

        // R8 / R9 overrun
        nine_bit = 1'b0;
        send_frame(9'h001, 1'b1, -1, 0, 1'b0);
        send_frame(9'h002, 1'b1, -1, 0, 1'b0);
        check_all("R7 two entries");
        send_frame(9'h003, 1'b1, -1, 0, 1'b0);
        check_all("R8 overrun set");
        chk(overrun == 1'b1, "R8 overrun flag", 16'(overrun), 16'h1);
        do_read("R8 first entry kept");
        send_frame(9'h004, 1'b1, -1, 0, 1'b0);
        check_all("R9 load blocked while overrun");
        toggle_en();
        check_all("R9 overrun cleared by enable");
        send_frame(9'h005, 1'b1, -1, 0, 1'b0);
        check_all("R9 load after clear");
        do_read("R9 read");
        do_read("R9 read");

        // R10 address filter
        nine_bit = 1'b1;
        addr_det = 1'b1;
        send_frame(9'h055, 1'b1, -1, 0, 1'b0);
        check_all("R10 data word dropped");
        send_frame(9'h1AA, 1'b1, -1, 0, 1'b0);
        send_frame(9'h1BB, 1'b1, -1, 0, 1'b0);
        send_frame(9'h066, 1'b1, -1, 0, 1'b0);
        check_all("R10 dropped word no overrun");
        do_read("R10 read");
        do_read("R10 read");
        nine_bit = 1'b0;
        send_frame(9'h077, 1'b1, -1, 0, 1'b0);
        check_all("R10 ignored in 8-bit mode");
        do_read("R10 read");
        addr_det = 1'b0;

        // R11 read on empty queue
        do_read("R11 empty read");
        send_frame(9'h0E7, 1'b1, -1, 0, 1'b0);
        check_all("R11 head after empty read");
        do_read("R11 single read empties");

        // R12 read and arrival in the same cycle on a full queue
        send_frame(9'h0A1, 1'b1, -1, 0, 1'b0);
        send_frame(9'h0A2, 1'b1, -1, 0, 1'b0);
        send_frame(9'h0A3, 1'b1, -1, 0, 1'b1);
        check_all("R12 collision accepted");
        do_read("R12 second entry");
        do_read("R12 new word read");

        // random mix
        for (int k = 0; k < 30; k++) begin
            logic [8:0] d;
            int         gb;
            nine_bit = 1'($urandom);
            addr_det = 1'($urandom);
            d  = 9'($urandom);
            gb = 1 + int'($urandom % 9);
            send_frame(d, ($urandom % 5) != 0, gb, 7 + int'($urandom % 3), 1'b0);
            check_all("R7 random frame");
            if (($urandom % 3) == 0) do_read("R7 random read");
            if (m_ovr && ($urandom % 2) == 0) begin
                toggle_en();
                check_all("R9 random enable toggle");
            end
        end

        summary();
        $finish;
    end
endmodule